// File: doc/BRIEF.md
# Four-Mode Shift Register with End-for-End Swap

This block is a small parallel register whose next value is chosen by two mode inputs. It can keep its contents, capture a parallel word, move its contents one place toward the most significant end while taking a new bit from a serial input, or swap its own bits end-for-end in a single clock. Every bit is fed by its own four-way selector in front of a flip-flop, so all bits move together from the old state on the same rising edge.

The register width is a parameter (default 4). An active-low asynchronous reset, released synchronously by the surrounding clock tree, forces the contents to zero. A separate synchronous clear input also zeroes the register on the next edge and overrides any mode. A typical use is to load a word, shift serial data through it, or turn a captured word into bit-reversed order without spending one cycle per bit.

Top module: `rev_shift_reg`

## Requirements
- R1: While `rst_n` is low, `q` is all zeros, whatever the other inputs are.
- R2: When `clr` is high at a rising edge, `q` becomes all zeros on that edge, whatever the mode inputs are.
- R3: With `clr` low and {`mode_a`,`mode_b`} = 2'b00, `q` keeps its value across the edge, and `par_in` and `ser_in` have no effect.
- R4: With `clr` low and {`mode_a`,`mode_b`} = 2'b01, `q` takes the value of `par_in`, bit i from `par_in[i]`.
- R5: With `clr` low and {`mode_a`,`mode_b`} = 2'b10, `q[i]` takes the old `q[i-1]` for i ≥ 1, `q[0]` takes `ser_in`, and the old most significant bit is dropped.
- R6: With `clr` low and {`mode_a`,`mode_b`} = 2'b11, `q[i]` takes the old `q[W-1-i]` for every i (for W = 4: bit 3 from old bit 0, bit 2 from old bit 1, and so on).
- R7: Every bit's new value is taken from the state held before the edge, never from a bit updated on the same edge; a run of shifts therefore holds the last W serial bits, newest in bit 0.
- R8: Two consecutive edges in mode 2'b11 return `q` to the value it held before the first of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear, overrides the mode |
| mode_a | input | 1 | Upper mode bit |
| mode_b | input | 1 | Lower mode bit |
| par_in | input | W | Parallel data word |
| ser_in | input | 1 | Serial data entering bit 0 on a shift |
| q | output | W | Register contents |

## Verification
On every cycle the checker confirms the edge-to-edge relation for each mode: contents stable when holding, equal to the previous parallel word on a load, shifted with the previous serial bit, or mirrored from the previous contents, and zero after a clear or during reset. What a single cycle cannot show is left to the bench scenarios: that a double swap restores the original word from every starting value, that a long run of shifts leaves exactly the last W serial bits, and that every mode behaves correctly from every one of the sixteen starting states with every parallel word and serial bit.

// File: rtl/rev_shift_reg_pkg.sv
package rev_shift_reg_pkg;

  typedef enum logic [1:0] {
    MD_KEEP  = 2'b00,
    MD_LOAD  = 2'b01,
    MD_SHIFT = 2'b10,
    MD_SWAP  = 2'b11
  } mode_e;

  localparam int unsigned NUM_SRC = 4;

  // one-hot source select positions
  localparam int unsigned SRC_OWN   = 0;
  localparam int unsigned SRC_PAR   = 1;
  localparam int unsigned SRC_SHIFT = 2;
  localparam int unsigned SRC_SWAP  = 3;

endpackage

// File: rtl/rev_shift_reg_ctrl.sv
module rev_shift_reg_ctrl
  import rev_shift_reg_pkg::*;
(
  input  logic               mode_a,
  input  logic               mode_b,
  input  logic               clr,
  output logic [NUM_SRC-1:0] src_sel,
  output logic               upd_en
);

  mode_e mode;

  always_comb begin
    mode = mode_e'({mode_a, mode_b});
  end

  always_comb begin
    src_sel = '0;
    unique case (mode)
      MD_KEEP:  src_sel[SRC_OWN]   = 1'b1;
      MD_LOAD:  src_sel[SRC_PAR]   = 1'b1;
      MD_SHIFT: src_sel[SRC_SHIFT] = 1'b1;
      MD_SWAP:  src_sel[SRC_SWAP]  = 1'b1;
      default:  src_sel[SRC_OWN]   = 1'b1;
    endcase
  end

  // the flops only need a clock enable when something changes
  always_comb begin
    upd_en = clr | (mode != MD_KEEP);
  end

endmodule

// File: rtl/rev_shift_reg_cell.sv
module rev_shift_reg_cell
  import rev_shift_reg_pkg::*;
(
  input  logic [NUM_SRC-1:0] src_sel,
  input  logic               clr,
  input  logic               own_bit,
  input  logic               par_bit,
  input  logic               shift_bit,
  input  logic               swap_bit,
  output logic               nxt_bit
);

  logic muxed;

  always_comb begin
    muxed = (src_sel[SRC_OWN]   & own_bit)
          | (src_sel[SRC_PAR]   & par_bit)
          | (src_sel[SRC_SHIFT] & shift_bit)
          | (src_sel[SRC_SWAP]  & swap_bit);
    nxt_bit = muxed & ~clr;
  end

endmodule

// File: rtl/rev_shift_reg.sv
module rev_shift_reg
  import rev_shift_reg_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         mode_a,
  input  logic         mode_b,
  input  logic [W-1:0] par_in,
  input  logic         ser_in,
  output logic [W-1:0] q
);

  localparam int unsigned MSB = W - 1;

  logic [NUM_SRC-1:0] src_sel;
  logic               upd_en;
  logic [W-1:0]       q_r;
  logic [W-1:0]       q_nxt;
  logic [W-1:0]       shift_src;
  logic [W-1:0]       swap_src;

  rev_shift_reg_ctrl u_ctrl (
    .mode_a  (mode_a),
    .mode_b  (mode_b),
    .clr     (clr),
    .src_sel (src_sel),
    .upd_en  (upd_en)
  );

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      if (i == 0) begin : g_lsb
        assign shift_src[i] = ser_in;
      end else begin : g_upper
        assign shift_src[i] = q_r[i-1];
      end
      assign swap_src[i] = q_r[MSB-i];

      rev_shift_reg_cell u_cell (
        .src_sel   (src_sel),
        .clr       (clr),
        .own_bit   (q_r[i]),
        .par_bit   (par_in[i]),
        .shift_bit (shift_src[i]),
        .swap_bit  (swap_src[i]),
        .nxt_bit   (q_nxt[i])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (upd_en) begin
      q_r <= q_nxt;
    end
  end

  assign q = q_r;

endmodule

// File: rtl/rev_shift_reg_chk.sv
module rev_shift_reg_chk #(
  parameter int unsigned W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clr,
  input logic         mode_a,
  input logic         mode_b,
  input logic [W-1:0] par_in,
  input logic         ser_in,
  input logic [W-1:0] q
);

  function automatic logic [W-1:0] mirror(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int k = 0; k < W; k++) r[k] = v[W-1-k];
    return r;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) AST_RESET_ZERO: assert (q == '0); // R1
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0)); // R2

  AST_KEEP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !mode_a && !mode_b) |=> $stable(q)); // R3

  AST_LOAD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !mode_a && mode_b) |=> (q == $past(par_in))); // R4

  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && mode_a && !mode_b) |=> (q == {$past(q[W-2:0]), $past(ser_in)})); // R5

  AST_SWAP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && mode_a && mode_b) |=> (q == mirror($past(q)))); // R6

endmodule

bind rev_shift_reg rev_shift_reg_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .clr    (clr),
  .mode_a (mode_a),
  .mode_b (mode_b),
  .par_in (par_in),
  .ser_in (ser_in),
  .q      (q)
);

// File: tb/rev_shift_reg_test.sv
`timescale 1ns/1ps
module rev_shift_reg_test;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         clr;
  logic         mode_a;
  logic         mode_b;
  logic [W-1:0] par_in;
  logic         ser_in;
  logic [W-1:0] q;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [W-1:0] model_q;

  always #2 clk = ~clk;

  rev_shift_reg #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .mode_a(mode_a), .mode_b(mode_b),
    .par_in(par_in), .ser_in(ser_in), .q(q)
  );

  function automatic logic [W-1:0] ref_next(input logic [W-1:0] cur, input logic a, b, c,
                                            input logic [W-1:0] p, input logic s);
    logic [W-1:0] r;
    if (c) return '0;
    case ({a, b})
      2'b00: r = cur;
      2'b01: r = p;
      2'b10: r = {cur[W-2:0], s};
      default: for (int k = 0; k < W; k++) r[k] = cur[W-1-k];
    endcase
    return r;
  endfunction

  task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: q=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // called at a negative edge; applies inputs for one rising edge, checks at next negedge
  task automatic step(input logic a, b, c, input logic [W-1:0] p, input logic s);
    string req;
    logic [W-1:0] exp;
    mode_a = a; mode_b = b; clr = c; par_in = p; ser_in = s;
    exp = ref_next(model_q, a, b, c, p, s);
    if (c) req = "R2";
    else case ({a, b})
      2'b00: req = "R3";
      2'b01: req = "R4";
      2'b10: req = "R5/R7";
      default: req = "R6/R7";
    endcase
    @(posedge clk);
    @(negedge clk);
    check(q, exp, req);
    model_q = exp;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: q=%b expected completion", q);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] start;
    logic [15:0]  lfsr;
    logic [W-1:0] hist;
    rst_n = 1'b0; clr = 1'b0; mode_a = 1'b1; mode_b = 1'b1; par_in = '1; ser_in = 1'b1;
    model_q = '0;
    repeat (3) @(negedge clk);
    check(q, '0, "R1");   // reset state
    rst_n = 1'b1;
    @(negedge clk);

    // exhaustive: every start state, mode, parallel word and serial bit
    for (int s0 = 0; s0 < 16; s0++)
      for (int m = 0; m < 4; m++)
        for (int p = 0; p < 16; p++)
          for (int si = 0; si < 2; si++) begin
            step(1'b0, 1'b1, 1'b0, W'(s0), 1'b0);
            step(m[1], m[0], 1'b0, W'(p), si[0]);
          end

    // clear beats every mode (R2)
    for (int m = 0; m < 4; m++) begin
      step(1'b0, 1'b1, 1'b0, 4'b1011, 1'b0);
      step(m[1], m[0], 1'b1, 4'b0110, 1'b1);
    end

    // two swaps restore the word (R8)
    for (int s0 = 0; s0 < 16; s0++) begin
      step(1'b0, 1'b1, 1'b0, W'(s0), 1'b0);
      start = W'(s0);
      step(1'b1, 1'b1, 1'b0, 4'b0000, 1'b1);
      step(1'b1, 1'b1, 1'b0, 4'b1111, 1'b0);
      check(q, start, "R8");
    end

    // long shift run: last W serial bits, newest in bit 0 (R7)
    lfsr = 16'hACE1; hist = '0;
    for (int n = 0; n < 200; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      hist = {hist[W-2:0], lfsr[0]};
      step(1'b1, 1'b0, 1'b0, ~hist, lfsr[0]);
      if (n >= W - 1) check(q, hist, "R7");
    end

    // asynchronous reset mid-run (R1)
    step(1'b0, 1'b1, 1'b0, 4'b1101, 1'b0);
    #1 rst_n = 1'b0;
    #0.5 check(q, '0, "R1");
    @(negedge clk);
    check(q, '0, "R1");
    rst_n = 1'b1;
    model_q = '0;
    step(1'b0, 1'b0, 1'b0, 4'b1111, 1'b1);   // hold after reset ignores inputs (R3)

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule